// File: doc/BRIEF.md
# Power-Management Event Status and System Control Interrupt Generator

This block keeps two groups of interrupt-source state for a power-management controller. The first group is a 16-bit event word: a status word whose bits latch hardware events, and an enable word that selects which latched events may interrupt. The second group is a small bank of general-purpose event bits, also with status and enable. A power-button pulse and one general-purpose event line set status bits. Software reads both groups, clears status bits by writing ones, and programs the enable masks.

All four registers sit behind a one-cycle register port. Each register accepts exactly one access width. An access of the wrong width is refused, reported on an error flag and changes nothing. The single level-sensitive interrupt output is high while any latched event is also enabled, in either group. Every status, enable and active register is a flop, so the interrupt follows one cycle after the write or event that changes it.

Top module: `acpi_sci_ctrl`

## Requirements
- R1: After reset all four registers read zero, `sci` is low and `acc_err` is low.
- R2: A write to the event status word (select 0) clears only bit 15 (wake), bit 10 (RTC), bit 9 (sleep button), bit 8 (power button) and bit 4 (bus master), and only where the written bit is 1. All other status bits ignore writes.
- R3: A write to the event enable word (select 1) keeps only bit 10 (RTC), bit 8 (power button) and bit 5 (global lock). Every other enable bit reads back as zero.
- R4: Size code 1 (two bytes) is the only accepted size at selects 0 and 1, and size code 0 (one byte) is the only accepted size at selects 2 and 3. Any other access raises `acc_err` on the next cycle, returns 0 on `acc_rdata` and leaves all registers unchanged.
- R5: A one-cycle `pwr_btn` pulse sets bit 8 of the event status word. If the bit is already set, it stays set.
- R6: A `gpe_evt` pulse sets general-purpose status bit GPE_LINE (bit 0 by default) at select 2.
- R7: General-purpose status (select 2) is write-one-to-clear, and general-purpose enable (select 3) stores written bits. Both keep only the valid bit GPE_LINE and read zero elsewhere.
- R8: `sci` is high exactly when (status AND enable) is nonzero over event bits 0, 5, 8, 9 and 10, or when (general-purpose status AND enable) is nonzero. It reflects the register state set on the previous clock edge.
- R9: If a status bit is set by its event input in the same cycle that a write clears it, the bit stays set.
- R10: An accepted read returns the selected register on `acc_rdata` in the cycle after the request. An accepted write leaves `acc_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Register access request, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Register select: 0 event status, 1 event enable, 2 GP status, 3 GP enable |
| acc_size | input | 2 | Access width code: 0 one byte, 1 two bytes, 2 four bytes, 3 reserved |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Registered read data |
| acc_err | output | 1 | Registered flag: the previous request was refused |
| pwr_btn | input | 1 | Power-button event pulse |
| gpe_evt | input | 1 | General-purpose event pulse |
| sci | output | 1 | Level system control interrupt |

## Verification
The assertions take the inputs as synchronous to `clk` and treat each cycle with `acc_req` high as one complete access. The check that a refused access leaves the event registers unchanged excludes any cycle in which `pwr_btn` arrives, because that event may legitimately set a status bit in the same cycle. The check that `sci` rises only after a stimulus assumes nothing else alters state. The bench keeps within these limits: every access lasts exactly one cycle, and events coincide with writes only in the deliberate set-versus-clear cases. The refused-width sweep also runs with event inputs held low.

// File: rtl/acpi_sci_pkg.sv
package acpi_sci_pkg;
  localparam int EVT_W = 16;

  // Event word bit positions
  localparam int B_TMR = 0;
  localparam int B_BM  = 4;
  localparam int B_GBL = 5;
  localparam int B_PWR = 8;
  localparam int B_SLP = 9;
  localparam int B_RTC = 10;
  localparam int B_WAK = 15;

  localparam logic [EVT_W-1:0] CLR_MASK =
    EVT_W'((1 << B_WAK) | (1 << B_RTC) | (1 << B_SLP) | (1 << B_PWR) | (1 << B_BM));
  localparam logic [EVT_W-1:0] EN_MASK =
    EVT_W'((1 << B_RTC) | (1 << B_PWR) | (1 << B_GBL));
  localparam logic [EVT_W-1:0] IRQ_MASK =
    EVT_W'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWR) | (1 << B_SLP) | (1 << B_RTC));

  typedef enum logic [1:0] {
    SEL_EVT_STS = 2'd0,
    SEL_EVT_EN  = 2'd1,
    SEL_GPE_STS = 2'd2,
    SEL_GPE_EN  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/acpi_evt_bank.sv
module acpi_evt_bank #(
  parameter int              W        = 16,
  parameter logic [W-1:0]    CLR_MASK = '0,
  parameter logic [W-1:0]    EN_MASK  = '0,
  parameter logic [W-1:0]    IRQ_MASK = '0,
  parameter int              SET_BIT  = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sts,
  input  logic         wr_en,
  input  logic         bad_acc,
  input  logic [W-1:0] wdata,
  input  logic         evt_set,
  output logic [W-1:0] sts_q,
  output logic [W-1:0] en_q,
  output logic         pend
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] set_vec;

  always_comb begin
    clr_vec = wr_sts ? (wdata & CLR_MASK) : '0;
    set_vec = '0;
    set_vec[SET_BIT] = evt_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | set_vec;  // set wins over clear
      if (wr_en) en_q <= wdata & EN_MASK;
    end
  end

  assign pend = |(sts_q & en_q & IRQ_MASK);

  assert_evt_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (bad_acc && !evt_set) |=> ($stable(sts_q) && $stable(en_q)));

  assert_pwr_set_R5: assert property (@(posedge clk) disable iff (rst)
    evt_set |=> sts_q[SET_BIT]);
endmodule

// File: rtl/acpi_gpe_bank.sv
module acpi_gpe_bank #(
  parameter int N    = 8,
  parameter int LINE = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sts,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  input  logic         evt,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] en_q,
  output logic         pend
);
  localparam logic [N-1:0] VALID = N'(1) << LINE;

  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~VALID);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic s_b, e_b;
      always_ff @(posedge clk) begin
        if (rst) begin
          s_b <= 1'b0;
          e_b <= 1'b0;
        end else begin
          if (wr_en) e_b <= wdata[i];
          if (evt) s_b <= 1'b1;               // raise beats W1C
          else if (wr_sts && wdata[i]) s_b <= 1'b0;
        end
      end
      assign sts_q[i] = s_b;
      assign en_q[i]  = e_b;
    end else begin : g_tie
      assign sts_q[i] = 1'b0;
      assign en_q[i]  = 1'b0;
    end
  end

  assign pend = |(sts_q & en_q);

  assert_gpe_set_R6: assert property (@(posedge clk) disable iff (rst)
    evt |=> sts_q[LINE]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (evt && wr_sts && wdata[LINE]) |=> sts_q[LINE]);
endmodule

// File: rtl/acpi_sci_ctrl.sv
module acpi_sci_ctrl #(
  parameter int GPE_N    = 8,
  parameter int GPE_LINE = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_req,
  input  logic        acc_we,
  input  logic [1:0]  acc_sel,
  input  logic [1:0]  acc_size,
  input  logic [15:0] acc_wdata,
  output logic [15:0] acc_rdata,
  output logic        acc_err,
  input  logic        pwr_btn,
  input  logic        gpe_evt,
  output logic        sci
);
  import acpi_sci_pkg::*;

  localparam int PAD = EVT_W - GPE_N;

  reg_sel_e        sel;
  logic            size_ok, good, bad;
  logic [EVT_W-1:0] evt_sts, evt_en;
  logic [GPE_N-1:0] gpe_sts, gpe_en;
  logic            evt_pend, gpe_pend;
  logic [EVT_W-1:0] rd_val;

  always_comb begin
    sel = reg_sel_e'(acc_sel);
    if (sel == SEL_EVT_STS || sel == SEL_EVT_EN) size_ok = (acc_size == SZ_WORD);
    else                                         size_ok = (acc_size == SZ_BYTE);
    good = acc_req && size_ok;
    bad  = acc_req && !size_ok;
    case (sel)
      SEL_EVT_STS: rd_val = evt_sts;
      SEL_EVT_EN:  rd_val = evt_en;
      SEL_GPE_STS: rd_val = {{PAD{1'b0}}, gpe_sts};
      default:     rd_val = {{PAD{1'b0}}, gpe_en};
    endcase
  end

  acpi_evt_bank #(
    .W(EVT_W), .CLR_MASK(CLR_MASK), .EN_MASK(EN_MASK),
    .IRQ_MASK(IRQ_MASK), .SET_BIT(B_PWR)
  ) evt_i (
    .clk(clk), .rst(rst),
    .wr_sts(good && acc_we && sel == SEL_EVT_STS),
    .wr_en (good && acc_we && sel == SEL_EVT_EN),
    .bad_acc(bad),
    .wdata(acc_wdata), .evt_set(pwr_btn),
    .sts_q(evt_sts), .en_q(evt_en), .pend(evt_pend)
  );

  acpi_gpe_bank #(.N(GPE_N), .LINE(GPE_LINE)) gpe_i (
    .clk(clk), .rst(rst),
    .wr_sts(good && acc_we && sel == SEL_GPE_STS),
    .wr_en (good && acc_we && sel == SEL_GPE_EN),
    .wdata(acc_wdata[GPE_N-1:0]), .evt(gpe_evt),
    .sts_q(gpe_sts), .en_q(gpe_en), .pend(gpe_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      acc_err <= bad;
      if (bad)                 acc_rdata <= '0;
      else if (good && !acc_we) acc_rdata <= rd_val;
    end
  end

  assign sci = evt_pend | gpe_pend;

  assert_err_next_R4: assert property (@(posedge clk) disable iff (rst)
    bad |=> acc_err);

  assert_sci_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sci) |-> $past(pwr_btn || gpe_evt || (acc_req && acc_we)));

  assert_wr_keeps_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    (good && acc_we) |=> $stable(acc_rdata));
endmodule

// File: tb/acpi_sci_ctrl_tb_top.sv
`timescale 1ns/100ps
module acpi_sci_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_req = 1'b0, acc_we = 1'b0;
  logic [1:0]  acc_sel = 2'd0, acc_size = 2'd0;
  logic [15:0] acc_wdata = 16'h0;
  logic [15:0] acc_rdata;
  logic        acc_err;
  logic        pwr_btn = 1'b0, gpe_evt = 1'b0;
  logic        sci;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Bench model
  logic [15:0] m_ests = 0, m_een = 0;
  logic [7:0]  m_gsts = 0, m_gen = 0;
  localparam logic [15:0] T_CLR = 16'h8710;
  localparam logic [15:0] T_EN  = 16'h0520;
  localparam logic [15:0] T_IRQ = 16'h0721;
  localparam logic [7:0]  T_GV  = 8'h01;

  always #2.5 clk = ~clk;

  acpi_sci_ctrl dut_i (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_we(acc_we),
    .acc_sel(acc_sel), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err),
    .pwr_btn(pwr_btn), .gpe_evt(gpe_evt), .sci(sci)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic exp_sci();
    return (|(m_ests & m_een & T_IRQ)) | (|(m_gsts & m_gen));
  endfunction

  // One cycle: optional access plus optional events; model updated.
  task automatic cyc(input logic req, input logic we, input logic [1:0] sel,
                     input logic [1:0] sz, input logic [15:0] d,
                     input logic pb, input logic ge);
    logic ok;
    @(negedge clk);
    acc_req = req; acc_we = we; acc_sel = sel; acc_size = sz; acc_wdata = d;
    pwr_btn = pb; gpe_evt = ge;
    ok = (sel < 2) ? (sz == 2'd1) : (sz == 2'd0);
    if (req && ok && we) begin
      case (sel)
        2'd0: m_ests = m_ests & ~(d & T_CLR);
        2'd1: m_een  = d & T_EN;
        2'd2: m_gsts = m_gsts & ~(d[7:0] & T_GV);
        default: m_gen = d[7:0] & T_GV;
      endcase
    end
    if (pb) m_ests[8] = 1'b1;
    if (ge) m_gsts[0] = 1'b1;
    @(negedge clk);
    acc_req = 0; acc_we = 0; pwr_btn = 0; gpe_evt = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    cyc(1, 1, sel, (sel < 2) ? 2'd1 : 2'd0, d, 0, 0);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] sel);
    logic [15:0] e;
    cyc(1, 0, sel, (sel < 2) ? 2'd1 : 2'd0, 16'h0, 0, 0);
    case (sel)
      2'd0: e = m_ests;
      2'd1: e = m_een;
      2'd2: e = {8'h0, m_gsts};
      default: e = {8'h0, m_gen};
    endcase
    chk(req, acc_rdata, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 sci", {15'h0, sci}, 16'h0);
    chk("R1 err", {15'h0, acc_err}, 16'h0);
    for (int s = 0; s < 4; s++) rd_chk("R1 reg", 2'(s));

    // R3 enable mask sweep
    for (int b = 0; b < 16; b++) begin
      wr(2'd1, 16'h1 << b);
      rd_chk("R3 en", 2'd1);
      chk("R8 sci no status", {15'h0, sci}, 16'h0);
    end
    wr(2'd1, 16'hFFFF); rd_chk("R3 en all", 2'd1);
    wr(2'd1, 16'h0);

    // R5 power button
    cyc(0, 0, 0, 0, 0, 1, 0);
    rd_chk("R5 pwr set", 2'd0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    rd_chk("R5 pwr hold", 2'd0);

    // R2 W1C mask
    wr(2'd0, 16'hFEFF); rd_chk("R2 other ones", 2'd0);
    chk("R2 bit kept", m_ests, 16'h0100);
    wr(2'd0, 16'h0100); rd_chk("R2 clear", 2'd0);

    // R6 / R7 general-purpose
    cyc(0, 0, 0, 0, 0, 0, 1);
    rd_chk("R6 gpe set", 2'd2);
    wr(2'd3, 16'h00FF); rd_chk("R7 gen mask", 2'd3);
    chk("R8 gpe sci", {15'h0, sci}, {15'h0, exp_sci()});
    wr(2'd2, 16'h00FE); rd_chk("R7 no clear", 2'd2);
    wr(2'd2, 16'h0001); rd_chk("R7 clear", 2'd2);
    wr(2'd3, 16'h0);

    // R8 exhaustive over power-button and GP status/enable
    for (int c = 0; c < 16; c++) begin
      wr(2'd0, 16'hFFFF); wr(2'd2, 16'h00FF);
      wr(2'd1, c[0] ? 16'h0100 : 16'h0);
      wr(2'd3, c[1] ? 16'h0001 : 16'h0);
      cyc(0, 0, 0, 0, 0, c[2], c[3]);
      chk("R8 sci", {15'h0, sci}, {15'h0, exp_sci()});
      chk("R8 sci expect", {15'h0, sci}, {15'h0, (c[0] & c[2]) | (c[1] & c[3])});
    end

    // R4 width sweep with nonzero state
    wr(2'd1, 16'h0100); cyc(0, 0, 0, 0, 0, 1, 1); wr(2'd3, 16'h1);
    for (int s = 0; s < 4; s++) begin
      for (int z = 0; z < 4; z++) begin
        logic ok;
        ok = (s < 2) ? (z == 1) : (z == 0);
        if (!ok) begin
          cyc(1, 1, 2'(s), 2'(z), 16'h0000, 0, 0);   // clear/disable attempt
          chk("R4 err", {15'h0, acc_err}, 16'h1);
          chk("R4 rdata", acc_rdata, 16'h0);
          chk("R4 sci kept", {15'h0, sci}, 16'h1);
          cyc(1, 1, 2'(s), 2'(z), 16'hFFFF, 0, 0);
          chk("R4 err", {15'h0, acc_err}, 16'h1);
          for (int r = 0; r < 4; r++) rd_chk("R4 unchanged", 2'(r));
          chk("R4 err clears", {15'h0, acc_err}, 16'h0);
        end
      end
    end

    // R9 set beats clear
    wr(2'd0, 16'hFFFF); wr(2'd2, 16'hFF);
    cyc(1, 1, 2'd0, 2'd1, 16'h0100, 1, 0);
    rd_chk("R9 pwr", 2'd0);
    cyc(1, 1, 2'd2, 2'd0, 16'h0001, 0, 1);
    rd_chk("R9 gpe", 2'd2);

    // R10 read then write keeps rdata
    rd_chk("R10 read", 2'd0);
    wr(2'd1, 16'h0000);
    chk("R10 hold after write", acc_rdata, m_ests);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule